// File: doc/BRIEF.md
# Head Positioning Command Sequencer

This block runs the head-movement class of a floppy disk controller: return to track zero, seek to a target track, and the three single-step commands (step again, step toward the spindle, step toward the rim). A register interface hands it an 8-bit command with a one-cycle `start` strobe. It also supplies the target track, a clock-speed select and the TEST pin level. The block then drives the drive's step strobe and direction line and keeps its own track register up to date. It raises `busy` while it works and gives a one-cycle `done` at the end.

The time between step strobes comes from a two-bit rate field in the command, scaled to the selected clock. When the TEST pin is low, the rate field is ignored and one short fixed period is used. A return to track zero that still sees no track-zero indication after a fixed number of strobes ends with an error flag. When the verify bit is set, the block does not read anything itself. It raises a verify request and waits for a pass or fail answer from outside.

All pins are plain control and status levels or strobes. The block has no streaming data path, so there is no valid/ready handshake. Software-visible behaviour comes only from `start`, `trk_we` and the status outputs.

Top module: `head_step_seq`

## Requirements
- R1: A `start` strobe in idle with `cmd[7]=0` is accepted and `busy` is high on the next cycle. A `start` with `cmd[7]=1`, or any `start` while busy, is ignored. Command decode uses `cmd[7:4]`: `0000` return-to-zero, `0001` seek, `001x` step, `010x` step-in, `011x` step-out. `cmd[4]` is the track-update bit for the three step commands, `cmd[3]` is head load, `cmd[2]` is verify and `cmd[1:0]` is the rate code.
- R2: With `test_pin=1`, rate codes 0, 1, 2 and 3 give 6, 12, 20 and 30 times `US_PER_MS*CLK_PER_US` clocks between rising edges of `step`. The period is halved when `clk2m_sel=1`.
- R3: With `test_pin=0`, the period is `TEST_US*CLK_PER_US` clocks whatever the rate code, and it is halved when `clk2m_sel=1`.
- R4: Each `step` strobe is exactly `PULSE_W` clocks high, and `step` is only high while `busy`.
- R5: Return-to-zero drives `dirc=0` and tests `tr00_n` before every strobe. When `tr00_n` is low it stops, sets the track register to 0 and leaves `seek_err` at 0. If `tr00_n` is already low, no strobe is issued.
- R6: If `RESTORE_LIMIT` (256) strobes have been issued and `tr00_n` is still high, return-to-zero ends with `seek_err=1` and the track register is left unchanged.
- R7: Seek strobes until the track register equals `dreg`. It uses `dirc=1` and +1 per strobe when `dreg` is greater, otherwise `dirc=0` and -1. When the two are already equal, no strobe is issued.
- R8: Step-in gives one strobe with `dirc=1` and step-out one strobe with `dirc=0`. The track register moves by one only when `cmd[4]=1`.
- R9: A plain step gives one strobe in the direction of the previous strobe, with the track update controlled by `cmd[4]`.
- R10: `head_load` takes `cmd[3]` when a command is accepted and holds it through completion, until the next accepted command.
- R11: With `cmd[2]=1` and no seek error, `verify_req` rises after the last step period and stays high until `verify_ok` or `verify_fail`. A fail sets `verify_err=1`. No strobe occurs while `verify_req` is high.
- R12: Completion gives a one-cycle `done` on the same edge that `busy` falls. `trk_we` loads the track register only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command strobe |
| cmd | input | 8 | Command byte |
| trk_we | input | 1 | Track register write enable (idle only) |
| trk_wdata | input | 8 | Track register write value |
| dreg | input | 8 | Target track for seek |
| clk2m_sel | input | 1 | 1 selects the doubled clock rate (halves periods) |
| test_pin | input | 1 | 1 selects the rate-code table, 0 the short fixed period |
| tr00_n | input | 1 | Track-zero indication, active low |
| verify_ok | input | 1 | External verify passed |
| verify_fail | input | 1 | External verify failed |
| step | output | 1 | Step strobe to drive |
| dirc | output | 1 | Direction: 1 toward centre, 0 toward edge |
| head_load | output | 1 | Head load request |
| verify_req | output | 1 | Request for external verify |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| seek_err | output | 1 | Track zero not found within limit |
| verify_err | output | 1 | Verify answered fail |
| trk | output | 8 | Track register |

## Verification
The bench builds the block with `CLK_PER_US=1`, `US_PER_MS=4`, `TEST_US=10` and `PULSE_W=3`. With these values every rate code and both clock selects give periods of 5 to 120 clocks, so the exact strobe spacing of the whole R2/R3 table can be measured within a short run. `RESTORE_LIMIT` keeps its default of 256, which keeps the full give-up path of return-to-zero within reach at the fastest period. A bench head-position model drives `tr00_n` from the observed strobes and direction.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    K_ZERO,
    K_SEEK,
    K_STEP,
    K_IN,
    K_OUT,
    K_NONE
  } cmd_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_DECIDE,
    S_WAIT,
    S_VERIFY
  } seq_state_e;

  function automatic cmd_kind_e decode_kind(input logic [7:0] c);
    cmd_kind_e k;
    case (c[7:5])
      3'b000:  k = c[4] ? K_SEEK : K_ZERO;
      3'b001:  k = K_STEP;
      3'b010:  k = K_IN;
      3'b011:  k = K_OUT;
      default: k = K_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/hs_rate_timer.sv
module hs_rate_timer #(
  parameter int CLK_PER_US = 1,
  parameter int US_PER_MS  = 1000,
  parameter int TEST_US    = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       test_pin,
  input  logic       fast,
  input  logic [1:0] rate,
  output logic       expired
);
  localparam int SLOW_MAX = 30 * US_PER_MS;
  localparam int MAXP     = ((SLOW_MAX > TEST_US) ? SLOW_MAX : TEST_US) * CLK_PER_US;
  localparam int CW       = $clog2(MAXP + 1);

  logic [CW-1:0] cnt;
  logic          running;
  int            period;
  int            base_ms;

  always_comb begin
    case (rate)
      2'd0:    base_ms = 6;
      2'd1:    base_ms = 12;
      2'd2:    base_ms = 20;
      default: base_ms = 30;
    endcase
    period = test_pin ? base_ms * US_PER_MS * CLK_PER_US : TEST_US * CLK_PER_US;
    if (fast) period = period / 2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= CW'(period - 2);
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign expired = running && (cnt == '0);

  a_r2_load_runs: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> running);
  a_r3_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/hs_pulse_gen.sv
module hs_pulse_gen #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int WW = $clog2(PULSE_W + 1);

  logic [WW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (fire)       left <= WW'(PULSE_W);
    else if (left != '0) left <= left - 1'b1;
  end

  assign pulse = (left != '0);

  a_r4_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !pulse);

endmodule

// File: rtl/head_step_seq.sv
module head_step_seq
  import hs_pkg::*;
#(
  parameter int CLK_PER_US    = 1,
  parameter int US_PER_MS     = 1000,
  parameter int TEST_US       = 400,
  parameter int PULSE_W       = 4,
  parameter int RESTORE_LIMIT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] cmd,
  input  logic       trk_we,
  input  logic [7:0] trk_wdata,
  input  logic [7:0] dreg,
  input  logic       clk2m_sel,
  input  logic       test_pin,
  input  logic       tr00_n,
  input  logic       verify_ok,
  input  logic       verify_fail,
  output logic       step,
  output logic       dirc,
  output logic       head_load,
  output logic       verify_req,
  output logic       busy,
  output logic       done,
  output logic       seek_err,
  output logic       verify_err,
  output logic [7:0] trk
);
  localparam int NW = $clog2(RESTORE_LIMIT + 1);

  seq_state_e state;
  cmd_kind_e  kind_q;
  logic [4:0] mods_q;
  logic [NW-1:0] npulse;
  logic       stepped;
  logic       expired;
  logic       accept;

  logic want_step, dir_n, upd_n, zero_n, err_n;

  assign accept = (state == S_IDLE) && start && (decode_kind(cmd) != K_NONE);

  always_comb begin
    want_step = 1'b0;
    dir_n     = dirc;
    upd_n     = 1'b0;
    zero_n    = 1'b0;
    err_n     = 1'b0;
    case (kind_q)
      K_ZERO: begin
        if (!tr00_n)                            zero_n = 1'b1;
        else if (npulse == NW'(RESTORE_LIMIT))  err_n  = 1'b1;
        else begin
          want_step = 1'b1;
          dir_n     = 1'b0;
        end
      end
      K_SEEK: begin
        if (trk != dreg) begin
          want_step = 1'b1;
          dir_n     = (dreg > trk);
          upd_n     = 1'b1;
        end
      end
      K_STEP, K_IN, K_OUT: begin
        if (!stepped) begin
          want_step = 1'b1;
          upd_n     = mods_q[4];
          if (kind_q == K_IN)  dir_n = 1'b1;
          if (kind_q == K_OUT) dir_n = 1'b0;
        end
      end
      default: ;
    endcase
  end

  wire issue = (state == S_DECIDE) && want_step;

  hs_rate_timer #(
    .CLK_PER_US(CLK_PER_US),
    .US_PER_MS (US_PER_MS),
    .TEST_US   (TEST_US)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (issue),
    .test_pin(test_pin),
    .fast    (clk2m_sel),
    .rate    (mods_q[1:0]),
    .expired (expired)
  );

  hs_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (issue),
    .pulse(step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind_q     <= K_NONE;
      mods_q     <= '0;
      npulse     <= '0;
      stepped    <= 1'b0;
      dirc       <= 1'b0;
      head_load  <= 1'b0;
      verify_req <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      seek_err   <= 1'b0;
      verify_err <= 1'b0;
      trk        <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            kind_q     <= decode_kind(cmd);
            mods_q     <= cmd[4:0];
            head_load  <= cmd[3];
            busy       <= 1'b1;
            seek_err   <= 1'b0;
            verify_err <= 1'b0;
            npulse     <= '0;
            stepped    <= 1'b0;
            state      <= S_DECIDE;
          end else if (trk_we) begin
            trk <= trk_wdata;
          end
        end
        S_DECIDE: begin
          if (want_step) begin
            dirc    <= dir_n;
            npulse  <= npulse + 1'b1;
            stepped <= 1'b1;
            if (upd_n) trk <= dir_n ? trk + 8'd1 : trk - 8'd1;
            state   <= S_WAIT;
          end else begin
            if (zero_n) trk <= '0;
            if (err_n)  seek_err <= 1'b1;
            if (mods_q[2] && !err_n) begin
              verify_req <= 1'b1;
              state      <= S_VERIFY;
            end else begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        S_WAIT: begin
          if (expired) state <= S_DECIDE;
        end
        S_VERIFY: begin
          if (verify_ok || verify_fail) begin
            verify_req <= 1'b0;
            verify_err <= verify_fail;
            busy       <= 1'b0;
            done       <= 1'b1;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_step_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy);
  a_r11_quiet_verify: assert property (@(posedge clk) disable iff (!rst_n)
    verify_req |-> !step);
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r1_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r7_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && trk != $past(trk)) |->
      (trk == $past(trk) + 8'd1 || trk == $past(trk) - 8'd1 || trk == 8'd0));
  a_r6_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seek_err) |-> done);

endmodule

// File: tb/head_step_seq_tb.sv
`timescale 1ns/1ps
module head_step_seq_tb;
  localparam int CLK_PER_US = 1;
  localparam int US_PER_MS  = 4;
  localparam int TEST_US    = 10;
  localparam int PULSE_W    = 3;
  localparam int LIMIT      = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] cmd = '0;
  logic trk_we = 1'b0;
  logic [7:0] trk_wdata = '0;
  logic [7:0] dreg = '0;
  logic clk2m_sel = 1'b0;
  logic test_pin = 1'b0;
  logic tr00_n;
  logic verify_ok = 1'b0;
  logic verify_fail = 1'b0;
  logic step, dirc, head_load, verify_req, busy, done, seek_err, verify_err;
  logic [7:0] trk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int base_pos = 1000;
  int epoch = 0;
  int seen_epoch = 0;
  int rises, net, imin, imax, wbad, rise_cyc, seen_up, seen_dn;
  logic prev_step = 1'b0;
  int saw_vreq;

  head_step_seq #(
    .CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS), .TEST_US(TEST_US),
    .PULSE_W(PULSE_W), .RESTORE_LIMIT(LIMIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .trk_we(trk_we),
    .trk_wdata(trk_wdata), .dreg(dreg), .clk2m_sel(clk2m_sel), .test_pin(test_pin),
    .tr00_n(tr00_n), .verify_ok(verify_ok), .verify_fail(verify_fail),
    .step(step), .dirc(dirc), .head_load(head_load), .verify_req(verify_req),
    .busy(busy), .done(done), .seek_err(seek_err), .verify_err(verify_err), .trk(trk)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign tr00_n = ((base_pos + net) != 0);

  always @(negedge clk) begin
    if (epoch != seen_epoch) begin
      seen_epoch = epoch;
      rises = 0; net = 0; imin = 1000000; imax = 0; wbad = 0;
      seen_up = 0; seen_dn = 0;
    end else begin
      if (step && !prev_step) begin
        rises++;
        if (rises > 1) begin
          if (cyc - rise_cyc < imin) imin = cyc - rise_cyc;
          if (cyc - rise_cyc > imax) imax = cyc - rise_cyc;
        end
        rise_cyc = cyc;
        if (dirc) begin net++; seen_up = 1; end
        else begin net--; seen_dn = 1; end
      end
      if (!step && prev_step && (cyc - rise_cyc != PULSE_W)) wbad++;
    end
    prev_step = step;
  end

  function automatic int exp_period(input bit t, input bit f, input int rr);
    int p;
    int ms [4] = '{6, 12, 20, 30};
    p = t ? ms[rr] * US_PER_MS * CLK_PER_US : TEST_US * CLK_PER_US;
    if (f) p = p / 2;
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_trk(input logic [7:0] v);
    @(negedge clk); trk_we = 1'b1; trk_wdata = v;
    @(negedge clk); trk_we = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] c, input bit vfail, input bit poke);
    int n;
    bit fin;
    @(negedge clk);
    base_pos = base_pos + net;
    epoch++;
    saw_vreq = 0;
    @(negedge clk);
    start = 1'b1; cmd = c;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after accept", busy, 1);
    fin = 0;
    for (int k = 0; k < 60000 && !fin; k++) begin
      @(negedge clk);
      trk_we = 1'b0; verify_ok = 1'b0; verify_fail = 1'b0;
      if (poke && k == 4) begin trk_we = 1'b1; trk_wdata = 8'h55; end
      if (done) begin
        fin = 1;
        chk(busy == 1'b0, "R12 busy falls with done", busy, 0);
      end else if (verify_req) begin
        saw_vreq++;
        if (step) chk(0, "R11 step during verify", 1, 0);
        if (saw_vreq == 3) begin
          if (vfail) verify_fail = 1'b1; else verify_ok = 1'b1;
        end
      end
    end
    if (!fin) chk(0, "R12 command timeout", 0, 1);
    @(negedge clk);
    verify_ok = 1'b0; verify_fail = 1'b0; trk_we = 1'b0;
    chk(done == 1'b0, "R12 done one cycle", done, 0);
    chk(wbad == 0, "R4 pulse width", wbad, 0);
  endtask

  task automatic do_seek(input int from, input int to, input bit t, input bit f,
                         input int rr, input bit h);
    write_trk(8'(from));
    dreg = 8'(to);
    test_pin = t; clk2m_sel = f;
    run_cmd({4'b0001, h, 1'b0, 2'(rr)}, 0, 0);
    chk(trk == 8'(to), "R7 seek final track", trk, to);
    chk(rises == ((to > from) ? to - from : from - to), "R7 seek pulse count", rises,
        (to > from) ? to - from : from - to);
    if (to > from) chk(seen_dn == 0 && seen_up == 1, "R7 seek direction in", seen_dn, 0);
    if (to < from) chk(seen_up == 0 && seen_dn == 1, "R7 seek direction out", seen_up, 0);
    if (rises > 1) begin
      chk(imin == exp_period(t, f, rr) && imax == imin, t ? "R2 period" : "R3 period",
          imax, exp_period(t, f, rr));
    end
    chk(head_load == h, "R10 head load held", head_load, h);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int seed;
    int a, b, rr;
    bit t, f, h;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && step == 0 && done == 0 && verify_req == 0, "R12 reset idle", busy, 0);
    chk(trk == 0 && seek_err == 0 && head_load == 0, "R10 reset outputs", trk, 0);

    // R1: command with bit 7 set is ignored
    write_trk(8'h21);
    @(negedge clk); start = 1'b1; cmd = 8'hD8;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 ignored command stays idle", busy, 1'b0);
    chk(trk == 8'h21 && head_load == 0, "R1 ignored command no effect", trk, 8'h21);

    // R5: return to zero from physical position 7
    write_trk(8'h20);
    base_pos = 7 - net;
    test_pin = 0; clk2m_sel = 0;
    run_cmd(8'h08, 0, 0);
    chk(rises == 7, "R5 restore pulses", rises, 7);
    chk(trk == 0, "R5 restore track zero", trk, 0);
    chk(seek_err == 0, "R5 restore no error", seek_err, 0);
    chk(seen_up == 0, "R5 restore outward only", seen_up, 0);
    chk(imin == 10 && imax == 10, "R3 restore period", imax, 10);
    chk(head_load == 1, "R10 head load set", head_load, 1);

    // R5: already at zero
    write_trk(8'h09);
    run_cmd(8'h00, 0, 0);
    chk(rises == 0 && trk == 0, "R5 restore at zero no pulse", rises, 0);
    chk(head_load == 0, "R10 head load cleared", head_load, 0);

    // R6: never reaches zero
    base_pos = 5000 - net;
    write_trk(8'h33);
    clk2m_sel = 1;
    run_cmd(8'h03, 0, 0);
    chk(rises == LIMIT, "R6 restore limit pulses", rises, LIMIT);
    chk(seek_err == 1, "R6 restore error flag", seek_err, 1);
    chk(trk == 8'h33, "R6 track unchanged", trk, 8'h33);
    chk(imin == 5, "R3 fast fixed period", imin, 5);

    // R2 / R3: full rate table via short seeks
    for (int tt = 0; tt < 2; tt++)
      for (int ff = 0; ff < 2; ff++)
        for (int r = 0; r < 4; r++)
          do_seek(10, 13, tt[0], ff[0], r, r[0]);

    // R7: seek with no distance, and outward seek
    do_seek(40, 40, 0, 0, 0, 0);
    do_seek(40, 35, 0, 1, 2, 1);

    // R8: step-in / step-out with and without update
    test_pin = 0; clk2m_sel = 0;
    write_trk(8'd10);
    run_cmd(8'h50, 0, 0);
    chk(trk == 11 && rises == 1 && dirc == 1, "R8 step-in update", trk, 11);
    run_cmd(8'h60, 0, 0);
    chk(trk == 11 && rises == 1 && dirc == 0, "R8 step-out no update", trk, 11);
    // R9: plain step repeats outward
    run_cmd(8'h30, 0, 0);
    chk(trk == 10 && rises == 1 && dirc == 0, "R9 step repeats outward", trk, 10);
    run_cmd(8'h40, 0, 0);
    chk(trk == 10 && dirc == 1, "R8 step-in no update", trk, 10);
    run_cmd(8'h30, 0, 0);
    chk(trk == 11 && dirc == 1 && seen_up == 1, "R9 step repeats inward", trk, 11);

    // R11: verify pass and fail
    write_trk(8'd3); dreg = 8'd5;
    run_cmd(8'h14, 0, 0);
    chk(saw_vreq > 0, "R11 verify requested", saw_vreq, 1);
    chk(verify_err == 0 && verify_req == 0, "R11 verify pass", verify_err, 0);
    dreg = 8'd6;
    run_cmd(8'h14, 1, 0);
    chk(verify_err == 1, "R11 verify fail flag", verify_err, 1);
    chk(trk == 6, "R11 track after verified seek", trk, 6);

    // R12: track write while busy is ignored
    dreg = 8'd9;
    run_cmd(8'h10, 0, 1);
    chk(trk == 9, "R12 busy track write ignored", trk, 9);

    // Random seeks
    for (int i = 0; i < 24; i++) begin
      a = $urandom_range(0, 60);
      t = 1'($urandom_range(0, 1));
      f = 1'($urandom_range(0, 1));
      rr = $urandom_range(0, 3);
      h = 1'($urandom_range(0, 1));
      b = t ? a + $urandom_range(0, 8) - 4 : $urandom_range(0, 60);
      if (b < 0) b = 0;
      do_seek(a, b, t, f, rr, h);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule